// File: doc/BRIEF.md
# Receive Buffer Ownership Manager

This block keeps track of which receive buffers in a host-memory descriptor ring belong to the network side, and decides where an accepted incoming frame is stored. On a routine poll tick it reads the current descriptor and then the following one, but only the ones it does not already hold. Once it holds both, routine polls cause no memory traffic at all. A ring of one entry has no following descriptor, so that entry is never looked ahead to.

When address filtering accepts a frame and no buffer is held, the block immediately makes one last-chance read of the current descriptor. If that read also fails, a missed-frame flag is raised (and an interrupt when enabled and unmasked), and the descriptor port stays silent until the frame ends. Otherwise the block looks ahead at the following descriptor and opens reception whatever that read returns. A byte-progress strobe is counted against the buffer length taken from the descriptor. On overrun the buffer is either chained into the next held buffer or returned with error status, and at frame end the buffer is returned with its byte count. Every hand-back is a single descriptor write that carries the status and the cleared ownership bit together.

Top module: `rxo_desc_mgr`

## Requirements
- R1: A routine poll tick in idle reads the current descriptor first if it is not held. If the current one is (or becomes) held, it then reads the following descriptor, provided that one is not held. A read word has ownership at bit 6 and the buffer length in bits 5:0.
- R2: While the current and following descriptors are both held, a poll tick produces no descriptor access.
- R3: With a ring length of one, no descriptor other than index 0 is ever accessed, and no look-ahead read occurs.
- R4: A frame accepted while the current buffer is not held causes an immediate read of the current descriptor, and that read is the first access after the acceptance.
- R5: If that last-chance read shows no ownership, the missed flag is set, and no descriptor access occurs, even on poll ticks, until the frame end strobe. The next poll tick after that reads the current descriptor again.
- R6: Once the current descriptor is held at acceptance, the following descriptor is read if not already held. Reception (rx_active) then opens whether or not that read shows ownership.
- R7: If a frame exceeds its buffer length and the following buffer is not held, the current descriptor is written with ownership 0, overflow-buffer bit 1, data-lost bit 1 and count equal to the buffer length. The rest of the frame produces no further access. Write word layout: bit 9 ownership, bit 8 end-of-frame, bit 7 overflow-buffer, bit 6 data-lost, bits 5:0 byte count.
- R8: If a frame exceeds its buffer length and the following buffer is held, the first descriptor is written with ownership 0, all flags 0 and count equal to its length. The descriptor after the new current one is then read (ring length above one), and the remaining bytes count into the second buffer.
- R9: At frame end the current descriptor is written with ownership 0, end-of-frame 1 and the byte count for that buffer, and the current index advances by one, modulo the ring length.
- R10: The interrupt output equals the missed flag while enabled and unmasked. The clear strobe drops the missed flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_len | input | 4 | Number of descriptors in the ring (1 to 8) |
| poll_tick | input | 1 | Routine poll request strobe |
| frame_acc | input | 1 | Address filter accepted a frame |
| frame_end | input | 1 | Frame has ended |
| byte_vld | input | 1 | One more frame byte has arrived |
| irq_en | input | 1 | Interrupt enable |
| miss_mask | input | 1 | Masks the missed-frame interrupt |
| miss_clr | input | 1 | Clears the missed flag |
| desc_req | output | 1 | Descriptor access request, held until acknowledged |
| desc_we | output | 1 | Access is a write |
| desc_idx | output | 3 | Descriptor ring index |
| desc_wdata | output | 10 | Status and ownership word for writes |
| desc_ack | input | 1 | Access complete, read data valid |
| desc_rdata | input | 7 | Ownership and buffer length read back |
| rx_active | output | 1 | Frame data may be stored |
| cur_idx | output | 3 | Index of the current descriptor |
| miss_flag | output | 1 | A frame was missed for lack of a buffer |
| irq | output | 1 | Missed-frame interrupt |

## Verification
The overrun decision and the frame-end decision can fall in the same cycle: the bench provokes this by raising the byte strobe that exceeds the buffer length together with the frame-end strobe. In both outcomes, chaining into a held buffer or returning with the error flags, it checks that the overrun write is made first. In the chained case a second, end-of-frame write must then carry a count of one into the next buffer. In the error case no end-of-frame write may follow. Frame lengths are swept across every count up to and beyond the buffer length, and ring lengths from one to four, with expected words assembled arithmetically from the field positions.

// File: rtl/rxo_pkg.sv
package rxo_pkg;
    localparam int IDX_W = 3;
    localparam int LEN_W = 6;
    localparam int CNT_W = LEN_W + 1;
    localparam int RD_W  = LEN_W + 1;
    localparam int WB_W  = LEN_W + 4;

    typedef struct packed {
        logic             own;
        logic [LEN_W-1:0] len;
    } rd_word_t;

    typedef struct packed {
        logic             own;
        logic             enp;
        logic             buff;
        logic             oflo;
        logic [LEN_W-1:0] mcnt;
    } wb_word_t;

    typedef enum logic [3:0] {
        S_IDLE, S_RD_CUR, S_RD_NXT, S_LD_CUR, S_LD_NXT, S_RECV,
        S_WB_END, S_WB_CHAIN, S_WB_BUFF, S_LOOK, S_DROP, S_MISS
    } st_t;

    function automatic wb_word_t mk_wb(input logic enp, input logic buff,
                                       input logic oflo, input logic [LEN_W-1:0] cnt);
        wb_word_t w;
        w.own  = 1'b0;
        w.enp  = enp;
        w.buff = buff;
        w.oflo = oflo;
        w.mcnt = cnt;
        return w;
    endfunction

    function automatic logic is_next_access(input st_t s);
        return (s == S_RD_NXT) || (s == S_LD_NXT) || (s == S_LOOK);
    endfunction
endpackage

// File: rtl/rxo_ring_ptr.sv
module rxo_ring_ptr
    import rxo_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W:0]   ring_len,
    input  logic             advance,
    output logic [IDX_W-1:0] cur,
    output logic [IDX_W-1:0] nxt
);
    logic [IDX_W:0] cur_plus;

    always_comb begin
        cur_plus = {1'b0, cur} + 1'b1;
        nxt      = (cur_plus >= ring_len) ? '0 : cur_plus[IDX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)          cur <= '0;
        else if (advance) cur <= nxt;
    end

    p_idx_in_ring_r9: assert property (@(posedge clk) disable iff (rst)
        ring_len != '0 |-> {1'b0, cur} < ring_len);
endmodule

// File: rtl/rxo_fill_cnt.sv
module rxo_fill_cnt
    import rxo_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    input  logic             sub_en,
    input  logic [LEN_W-1:0] sub_val,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] sub_amt;

    always_comb sub_amt = sub_en ? {1'b0, sub_val} : '0;

    always_ff @(posedge clk) begin
        if (rst)      cnt <= '0;
        else if (clr) cnt <= {{(CNT_W-1){1'b0}}, inc};
        else          cnt <= cnt - sub_amt + {{(CNT_W-1){1'b0}}, inc};
    end
endmodule

// File: rtl/rxo_ctrl.sv
module rxo_ctrl
    import rxo_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W:0]   ring_len,
    input  logic             poll_tick,
    input  logic             frame_acc,
    input  logic             frame_end,
    input  logic             byte_vld,
    input  logic [IDX_W-1:0] cur,
    input  logic [IDX_W-1:0] nxt,
    input  logic [CNT_W-1:0] cnt,
    input  logic             desc_ack,
    input  logic [RD_W-1:0]  desc_rdata,
    output logic             desc_req,
    output logic             desc_we,
    output logic [IDX_W-1:0] desc_idx,
    output logic [WB_W-1:0]  desc_wdata,
    output logic             advance,
    output logic             cnt_clr,
    output logic             cnt_inc,
    output logic             cnt_sub,
    output logic [LEN_W-1:0] cur_len_o,
    output logic             miss_set,
    output logic             rx_active
);
    st_t              st;
    logic             cur_own, nxt_own;
    logic [LEN_W-1:0] cur_len, nxt_len;
    logic             acc_pend, end_pend, in_frame;
    logic             multi;
    rd_word_t         rd;
    wb_word_t         wb;
    logic             overrun;

    always_comb begin
        rd        = rd_word_t'(desc_rdata);
        multi     = ring_len > 1;
        overrun   = cnt > {1'b0, cur_len};
        desc_req  = !(st == S_IDLE || st == S_RECV || st == S_DROP || st == S_MISS);
        desc_we   = (st == S_WB_END) || (st == S_WB_CHAIN) || (st == S_WB_BUFF);
        desc_idx  = is_next_access(st) ? nxt : cur;
        unique case (st)
            S_WB_END:   wb = mk_wb(1'b1, 1'b0, 1'b0, cnt[LEN_W-1:0]);
            S_WB_BUFF:  wb = mk_wb(1'b0, 1'b1, 1'b1, cur_len);
            default:    wb = mk_wb(1'b0, 1'b0, 1'b0, cur_len);
        endcase
        desc_wdata = desc_we ? WB_W'(wb) : '0;
        advance    = desc_ack && desc_we;
        cnt_clr    = (st == S_IDLE) && acc_pend;
        cnt_inc    = byte_vld && (in_frame || cnt_clr);
        cnt_sub    = desc_ack && (st == S_WB_CHAIN);
        cur_len_o  = cur_len;
        miss_set   = desc_ack && (st == S_LD_CUR) && !rd.own;
        rx_active  = (st == S_RECV) || (st == S_WB_CHAIN) || (st == S_LOOK);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            cur_own  <= 1'b0;
            nxt_own  <= 1'b0;
            cur_len  <= '0;
            nxt_len  <= '0;
            acc_pend <= 1'b0;
            end_pend <= 1'b0;
            in_frame <= 1'b0;
        end else begin
            if (frame_acc && !in_frame) acc_pend <= 1'b1;
            if (frame_end && (in_frame || acc_pend)) end_pend <= 1'b1;
            if (advance) begin
                cur_own <= multi ? nxt_own : 1'b0;
                cur_len <= nxt_len;
                nxt_own <= 1'b0;
            end
            unique case (st)
                S_IDLE: begin
                    if (acc_pend) begin
                        acc_pend <= 1'b0;
                        in_frame <= 1'b1;
                        if (!cur_own)                st <= S_LD_CUR;
                        else if (multi && !nxt_own)  st <= S_LD_NXT;
                        else                         st <= S_RECV;
                    end else if (poll_tick) begin
                        if (!cur_own)                st <= S_RD_CUR;
                        else if (multi && !nxt_own)  st <= S_RD_NXT;
                    end
                end
                S_RD_CUR, S_LD_CUR: if (desc_ack) begin
                    cur_own <= rd.own;
                    cur_len <= rd.len;
                    if (rd.own && multi && !nxt_own)
                        st <= (st == S_RD_CUR) ? S_RD_NXT : S_LD_NXT;
                    else if (st == S_RD_CUR)
                        st <= S_IDLE;
                    else
                        st <= rd.own ? S_RECV : S_MISS;
                end
                S_RD_NXT, S_LD_NXT, S_LOOK: if (desc_ack) begin
                    nxt_own <= rd.own;
                    nxt_len <= rd.len;
                    st      <= (st == S_RD_NXT) ? S_IDLE : S_RECV;
                end
                S_RECV: begin
                    if (overrun)       st <= nxt_own ? S_WB_CHAIN : S_WB_BUFF;
                    else if (end_pend) st <= S_WB_END;
                end
                S_WB_END: if (desc_ack) begin
                    end_pend <= 1'b0;
                    in_frame <= 1'b0;
                    st       <= S_IDLE;
                end
                S_WB_CHAIN: if (desc_ack) st <= multi ? S_LOOK : S_RECV;
                S_WB_BUFF:  if (desc_ack) st <= S_DROP;
                S_DROP, S_MISS: if (end_pend) begin
                    end_pend <= 1'b0;
                    in_frame <= 1'b0;
                    st       <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    p_skip_held_r2: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE && poll_tick && !acc_pend && cur_own && nxt_own) |=> !desc_req);
    p_single_ring_r3: assert property (@(posedge clk) disable iff (rst)
        (desc_req && ring_len == 1) |-> desc_idx == '0);
    p_quiet_miss_r5: assert property (@(posedge clk) disable iff (rst)
        (st == S_MISS) |-> !desc_req);
    p_handback_own_r7: assert property (@(posedge clk) disable iff (rst)
        (desc_req && desc_we) |-> !desc_wdata[WB_W-1]);
    p_req_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (desc_req && !desc_ack) |=> desc_req && $stable(desc_idx) && $stable(desc_we));
    p_buff_needs_unheld_r8: assert property (@(posedge clk) disable iff (rst)
        (st == S_RECV && overrun && nxt_own) |=> st == S_WB_CHAIN);
endmodule

// File: rtl/rxo_desc_mgr.sv
module rxo_desc_mgr
    import rxo_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W:0]   ring_len,
    input  logic             poll_tick,
    input  logic             frame_acc,
    input  logic             frame_end,
    input  logic             byte_vld,
    input  logic             irq_en,
    input  logic             miss_mask,
    input  logic             miss_clr,
    output logic             desc_req,
    output logic             desc_we,
    output logic [IDX_W-1:0] desc_idx,
    output logic [WB_W-1:0]  desc_wdata,
    input  logic             desc_ack,
    input  logic [RD_W-1:0]  desc_rdata,
    output logic             rx_active,
    output logic [IDX_W-1:0] cur_idx,
    output logic             miss_flag,
    output logic             irq
);
    logic [IDX_W-1:0] nxt;
    logic [CNT_W-1:0] cnt;
    logic [LEN_W-1:0] cur_len;
    logic             advance, cnt_clr, cnt_inc, cnt_sub, miss_set;

    rxo_ring_ptr u_ptr (
        .clk(clk), .rst(rst), .ring_len(ring_len), .advance(advance),
        .cur(cur_idx), .nxt(nxt)
    );

    rxo_fill_cnt u_cnt (
        .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cnt_inc),
        .sub_en(cnt_sub), .sub_val(cur_len), .cnt(cnt)
    );

    rxo_ctrl u_ctrl (
        .clk(clk), .rst(rst), .ring_len(ring_len), .poll_tick(poll_tick),
        .frame_acc(frame_acc), .frame_end(frame_end), .byte_vld(byte_vld),
        .cur(cur_idx), .nxt(nxt), .cnt(cnt), .desc_ack(desc_ack),
        .desc_rdata(desc_rdata), .desc_req(desc_req), .desc_we(desc_we),
        .desc_idx(desc_idx), .desc_wdata(desc_wdata), .advance(advance),
        .cnt_clr(cnt_clr), .cnt_inc(cnt_inc), .cnt_sub(cnt_sub),
        .cur_len_o(cur_len), .miss_set(miss_set), .rx_active(rx_active)
    );

    always_ff @(posedge clk) begin
        if (rst)           miss_flag <= 1'b0;
        else if (miss_set) miss_flag <= 1'b1;
        else if (miss_clr) miss_flag <= 1'b0;
    end

    always_comb irq = miss_flag && irq_en && !miss_mask;

    p_miss_raise_r5: assert property (@(posedge clk) disable iff (rst)
        miss_set |=> miss_flag);
    p_miss_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (miss_clr && !miss_set) |=> !miss_flag);
endmodule

// File: tb/rxo_desc_mgr_tb.sv
module rxo_desc_mgr_tb;
    localparam int CLK_PERIOD = 10;
    localparam int IW = 3;
    localparam int LW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [IW:0]   ring_len = 4'd4;
    logic          poll_tick = 0, frame_acc = 0, frame_end = 0, byte_vld = 0;
    logic          irq_en = 0, miss_mask = 0, miss_clr = 0;
    logic          desc_req, desc_we, desc_ack, rx_active, miss_flag, irq;
    logic [IW-1:0] desc_idx, cur_idx;
    logic [LW+3:0] desc_wdata;
    logic [LW:0]   desc_rdata;

    logic          own_m [8];
    logic [LW-1:0] len_m [8];
    logic          cfg_we = 0, cfg_own = 0, clr_log = 0;
    logic [IW-1:0] cfg_idx = 0;
    logic [LW-1:0] cfg_len = 0;
    logic          lg_we  [16];
    logic [IW-1:0] lg_idx [16];
    logic [LW+3:0] lg_dat [16];
    int            nlog;
    int            n_chk = 0, n_fail = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxo_desc_mgr u_dut (
        .clk(clk), .rst(rst), .ring_len(ring_len), .poll_tick(poll_tick),
        .frame_acc(frame_acc), .frame_end(frame_end), .byte_vld(byte_vld),
        .irq_en(irq_en), .miss_mask(miss_mask), .miss_clr(miss_clr),
        .desc_req(desc_req), .desc_we(desc_we), .desc_idx(desc_idx),
        .desc_wdata(desc_wdata), .desc_ack(desc_ack), .desc_rdata(desc_rdata),
        .rx_active(rx_active), .cur_idx(cur_idx), .miss_flag(miss_flag), .irq(irq)
    );

    // descriptor memory model with one-cycle acknowledge and access log
    always_ff @(posedge clk) begin
        desc_ack <= desc_req && !desc_ack;
        if (desc_req && !desc_ack) desc_rdata <= {own_m[desc_idx], len_m[desc_idx]};
        if (cfg_we) begin
            own_m[cfg_idx] <= cfg_own;
            len_m[cfg_idx] <= cfg_len;
        end
        if (clr_log) nlog <= 0;
        else if (desc_ack && desc_req) begin
            if (nlog < 16) begin
                lg_we[nlog]  <= desc_we;
                lg_idx[nlog] <= desc_idx;
                lg_dat[nlog] <= desc_wdata;
            end
            if (desc_we) begin
                own_m[desc_idx] <= desc_wdata[LW+3];
                len_m[desc_idx] <= desc_wdata[LW-1:0];
            end
            nlog <= nlog + 1;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_fail = n_fail + 1;
            n_chk  = n_chk + 1;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_desc(input int i, input logic o, input int l);
        cfg_we = 1; cfg_idx = IW'(i); cfg_own = o; cfg_len = LW'(l);
        tick(1);
        cfg_we = 0;
    endtask

    task automatic do_reset(input int len);
        ring_len = (IW+1)'(len);
        rst = 1; clr_log = 1;
        for (int i = 0; i < 8; i++) set_desc(i, 1'b0, 4);
        tick(2);
        rst = 0; clr_log = 0;
        tick(1);
    endtask

    task automatic pulse(ref logic s);
        s = 1; tick(1); s = 0; tick(12);
    endtask

    task automatic send_bytes(input int n, input logic end_with_last);
        for (int b = 0; b < n; b++) begin
            byte_vld = 1;
            if (end_with_last && b == n - 1) frame_end = 1;
            tick(1);
            byte_vld = 0; frame_end = 0;
            tick(3);
        end
        tick(12);
    endtask

    task automatic chk_log(input int k, input logic we, input int idx, input int dat, input string tag);
        chk(lg_we[k] == we && int'(lg_idx[k]) == idx && (!we || int'(lg_dat[k]) == dat),
            tag, we ? int'(lg_dat[k]) : int'(lg_idx[k]), we ? dat : idx);
    endtask

    // write word: bit9 own, bit8 end-of-frame, bit7 overflow-buffer, bit6 data-lost, bits5:0 count
    function automatic int wword(input int enp, input int bf, input int of, input int c);
        return (enp << 8) | (bf << 7) | (of << 6) | c;
    endfunction

    initial begin
        do_reset(4);
        chk(!desc_req && !rx_active && !miss_flag && !irq && cur_idx == 0, "reset",
            {desc_req, rx_active, miss_flag, irq}, 0);

        // R1/R2/R3: poll sweep over ring lengths
        for (int L = 1; L <= 4; L++) begin
            do_reset(L);
            for (int i = 0; i < L; i++) set_desc(i, 1'b1, 8);
            pulse(poll_tick);
            chk(nlog == (L == 1 ? 1 : 2), "R1 poll count", nlog, L == 1 ? 1 : 2);
            chk_log(0, 1'b0, 0, 0, "R1 current first");
            if (L > 1) chk_log(1, 1'b0, 1, 0, "R1 next second");
            else chk(nlog == 1, "R3 no lookahead", nlog, 1);
            pulse(poll_tick);
            chk(nlog == (L == 1 ? 1 : 2), "R2 held skip", nlog, L == 1 ? 1 : 2);
        end

        // R3: single-entry ring overrun has no next buffer
        do_reset(1);
        set_desc(0, 1'b1, 4);
        pulse(frame_acc);
        send_bytes(6, 1'b0);
        pulse(frame_end);
        chk(nlog == 2, "R3 single ring accesses", nlog, 2);
        chk_log(1, 1'b1, 0, wword(0, 1, 1, 4), "R3 single ring buff");

        // R4/R5/R10: last-chance poll failure, interrupt gating sweep
        do_reset(4);
        pulse(frame_acc);
        chk(nlog == 1, "R4 one immediate read", nlog, 1);
        chk_log(0, 1'b0, 0, 0, "R4 current read");
        chk(miss_flag == 1, "R5 miss set", miss_flag, 1);
        for (int e = 0; e < 2; e++) for (int m = 0; m < 2; m++) begin
            irq_en = e[0]; miss_mask = m[0]; tick(1);
            chk(irq == (e == 1 && m == 0), "R10 irq gating", irq, e == 1 && m == 0);
        end
        pulse(poll_tick);
        chk(nlog == 1, "R5 silent until end", nlog, 1);
        pulse(frame_end);
        pulse(poll_tick);
        chk(nlog == 2 && lg_idx[1] == 0, "R5 poll resumes", nlog, 2);
        pulse(miss_clr);
        chk(miss_flag == 0 && irq == 0, "R10 clear", miss_flag, 0);
        irq_en = 0;

        // R6/R9: frame lengths 1..5 into a 5-byte buffer, next unheld
        for (int n = 1; n <= 5; n++) begin
            do_reset(4);
            set_desc(0, 1'b1, 5);
            pulse(frame_acc);
            chk(rx_active == 1, "R6 reception open", rx_active, 1);
            chk(nlog == 2 && lg_idx[1] == 1 && !lg_we[1], "R6 next read", nlog, 2);
            send_bytes(n, 1'b0);
            pulse(frame_end);
            chk(nlog == 3, "R9 one write", nlog, 3);
            chk_log(2, 1'b1, 0, wword(1, 0, 0, n), "R9 end status");
            chk(cur_idx == 1 && rx_active == 0, "R9 advance", cur_idx, 1);
        end

        // R7: overrun with next unheld, separate and same-cycle end
        for (int sim = 0; sim < 2; sim++) begin
            do_reset(4);
            set_desc(0, 1'b1, 4);
            pulse(frame_acc);
            send_bytes(sim == 1 ? 5 : 6, sim == 1);
            if (sim == 0) pulse(frame_end);
            chk(nlog == 3, "R7 access count", nlog, 3);
            chk_log(2, 1'b1, 0, wword(0, 1, 1, 4), "R7 buff status");
            chk(cur_idx == 1 && rx_active == 0, "R7 dropped rest", rx_active, 0);
        end

        // R8: overrun chained into held next buffer, sweep + same-cycle end
        for (int n = 5; n <= 8; n++) begin
            do_reset(4);
            set_desc(0, 1'b1, 4);
            set_desc(1, 1'b1, 8);
            pulse(frame_acc);
            send_bytes(n == 8 ? 5 : n, n == 8);
            if (n != 8) pulse(frame_end);
            chk(nlog == 5, "R8 access count", nlog, 5);
            chk_log(2, 1'b1, 0, wword(0, 0, 0, 4), "R8 first buffer");
            chk_log(3, 1'b0, 2, 0, "R8 lookahead third");
            chk_log(4, 1'b1, 1, wword(1, 0, 0, (n == 8 ? 5 : n) - 4), "R8 second buffer R9");
            chk(cur_idx == 2, "R8 index", cur_idx, 2);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule